// File: doc/BRIEF.md
# Time-Base Divider with Rate Selection

This block turns a 32.768 kHz time-base enable into the slow timing events of a real-time clock. A 15-stage binary divider advances by one on every cycle in which the time-base enable is high. A 3-bit oscillator-control field gates the divider, and a 4-bit rate code picks one of the divider's outputs. The chosen output drives a square-wave pin and a periodic event pulse. Each of the two has its own enable.

The divider is treated as a single 15-bit count. Bit k of the count toggles at 32768 / 2^(k+1) Hz. When the count wraps from all ones back to zero, the block raises a once-per-second update tick. All three outputs are registered. Each one reflects the count as it stands after the same clock edge.

Top module: `tbase_rate_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the divider count returns to zero and `sqw_out`, `periodic_pulse` and `second_tick` are low after that edge.
- R2: With `osc_ctl` = 3'b010, the count rises by one at each edge where `tb_en` is high, wraps modulo 2^15, and is unchanged at edges where `tb_en` is low.
- R3: With `osc_ctl[2:1]` = 2'b11, the count is forced to zero and held there, and no periodic pulse or second tick is issued.
- R4: With any `osc_ctl` value other than 3'b010 or 3'b11x, the count is frozen, no periodic pulse or second tick is issued, and `sqw_out` keeps the level of the frozen count.
- R5: The rate code `rate_sel` picks a count bit as follows: 1 selects bit 6 (256 Hz), 2 selects bit 7 (128 Hz), 3 selects bit 1 (8192 Hz), and each code n from 4 to 15 selects bit n-2 (4096 Hz down to 2 Hz, halving per step).
- R6: With `rate_sel` = 0 no bit is selected, so `sqw_out` stays low and no periodic pulse is issued.
- R7: `sqw_out` equals the selected count bit after the edge when `sqw_en` is 1, and it is low when `sqw_en` is 0.
- R8: `periodic_pulse` is high for exactly one cycle after each edge at which the selected count bit goes from 0 to 1 through an increment, provided `pie_en` is 1. The value of `sqw_en` has no effect on it.
- R9: `second_tick` is high for one cycle after each edge at which the count wraps from all ones to zero. After a release from the hold state with `tb_en` continuously high, the first tick follows the 32768th enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_en | input | 1 | 32.768 kHz time-base enable, one cycle per time-base period |
| osc_ctl | input | 3 | Oscillator control: 010 run, 11x hold count at zero, other values off |
| rate_sel | input | 4 | Rate code selecting the divider bit |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Periodic event enable |
| sqw_out | output | 1 | Square wave at the selected rate, low when disabled |
| periodic_pulse | output | 1 | One-cycle pulse on each rising edge of the selected bit |
| second_tick | output | 1 | One-cycle pulse each time the divider wraps |

## Verification
If the count holds a wrong value, it shows up at once as a wrong `sqw_out` level at the fast rates. At the slow rates it shows up within one period of the selected bit, as a shifted pulse. A fault in the oscillator-control decode shows up as pulses while the divider should be off or held, or as a first second tick that is not exactly 32768 enabled edges after the release. A wrong entry in the rate map gives a wrong square-wave level within 2^(k+1) enables, where k is the bit that should have been selected. It also gives a wrong pulse count over a window of four half-periods.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  localparam int RS_W  = 4;
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             valid;
    logic [IDX_W-1:0] idx;
  } tap_sel_t;

  // Rate code to divider bit. Code 0 selects nothing. Codes 1 and 2 reach the
  // slow bits 6 and 7, code 3 reaches bit 1, and from code 4 onwards the bit
  // index is the code minus two.
  function automatic tap_sel_t map_rate(input logic [RS_W-1:0] rs);
    tap_sel_t s;
    s.valid = 1'b1;
    case (rs)
      4'd0:    begin s.valid = 1'b0; s.idx = '0;    end
      4'd1:    s.idx = 4'd6;
      4'd2:    s.idx = 4'd7;
      4'd3:    s.idx = 4'd1;
      default: s.idx = rs - 4'd2;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/tbr_osc_ctl.sv
module tbr_osc_ctl (
  input  logic       tb_en,
  input  logic [2:0] osc_field,
  output logic       adv,
  output logic       clr
);

  // Hold when the two upper bits are set; run only for the single pattern 010.
  logic run_mode;

  always_comb begin
    clr      = (osc_field[2:1] == 2'b11);
    run_mode = (osc_field == 3'b010);
    adv      = run_mode & tb_en;
  end

endmodule

// File: rtl/tbr_divider.sv
module tbr_divider #(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              clr,
  output logic [STAGES-1:0] cnt_nxt,
  output logic [STAGES-1:0] rise,
  output logic              wrap
);

  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt + 1'b1;
    if (rst || clr)  cnt_nxt = '0;
    else if (adv)    cnt_nxt = cnt_inc;
    else             cnt_nxt = cnt;
    // Bits that go from 0 to 1 because of this increment.
    rise = (adv && !clr) ? (cnt_inc & ~cnt) : '0;
    wrap = adv && !clr && (&cnt);
  end

  always_ff @(posedge clk) begin
    cnt <= cnt_nxt;
  end

  assert_hold_clears_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  assert_off_freezes_R4: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> (cnt == $past(cnt)));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr) |=> (cnt == STAGES'($past(cnt) + 1'b1)));

  assert_rise_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rise));

endmodule

// File: rtl/tbr_tap_mux.sv
module tbr_tap_mux
  import tbr_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RS_W-1:0]   rate_sel,
  input  logic              sqw_en,
  input  logic              pie_en,
  input  logic [STAGES-1:0] cnt_nxt,
  input  logic [STAGES-1:0] rise,
  input  logic              wrap,
  output logic              sqw_out,
  output logic              periodic_pulse,
  output logic              second_tick
);

  localparam int NUM_RS = 1 << RS_W;

  logic [NUM_RS-1:0] lvl;
  logic [NUM_RS-1:0] edg;

  for (genvar g = 0; g < NUM_RS; g++) begin : g_rs
    localparam tap_sel_t SEL = map_rate(RS_W'(g));
    if (SEL.valid) begin : g_tap
      assign lvl[g] = cnt_nxt[SEL.idx];
      assign edg[g] = rise[SEL.idx];
    end else begin : g_none
      assign lvl[g] = 1'b0;
      assign edg[g] = 1'b0;
    end
  end

  // Bits of the divider that no rate code reaches.
  logic unused_bits;
  assign unused_bits = ^{cnt_nxt[0], cnt_nxt[STAGES-1], rise[0], rise[STAGES-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sqw_out        <= 1'b0;
      periodic_pulse <= 1'b0;
      second_tick    <= 1'b0;
    end else begin
      sqw_out        <= sqw_en & lvl[rate_sel];
      periodic_pulse <= pie_en & edg[rate_sel];
      second_tick    <= wrap;
    end
  end

  assert_sqw_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !sqw_en |=> !sqw_out);

  assert_rs_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rate_sel == '0) |=> (!sqw_out && !periodic_pulse));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    periodic_pulse |=> !periodic_pulse);

endmodule

// File: rtl/tbase_rate_gen.sv
module tbase_rate_gen
  import tbr_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tb_en,
  input  logic [2:0]      osc_ctl,
  input  logic [RS_W-1:0] rate_sel,
  input  logic            sqw_en,
  input  logic            pie_en,
  output logic            sqw_out,
  output logic            periodic_pulse,
  output logic            second_tick
);

  logic              adv;
  logic              clr;
  logic [STAGES-1:0] cnt_nxt;
  logic [STAGES-1:0] rise;
  logic              wrap;

  tbr_osc_ctl u_osc (
    .tb_en     (tb_en),
    .osc_field (osc_ctl),
    .adv       (adv),
    .clr       (clr)
  );

  tbr_divider #(.STAGES(STAGES)) u_div (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .clr     (clr),
    .cnt_nxt (cnt_nxt),
    .rise    (rise),
    .wrap    (wrap)
  );

  tbr_tap_mux #(.STAGES(STAGES)) u_mux (
    .clk            (clk),
    .rst            (rst),
    .rate_sel       (rate_sel),
    .sqw_en         (sqw_en),
    .pie_en         (pie_en),
    .cnt_nxt        (cnt_nxt),
    .rise           (rise),
    .wrap           (wrap),
    .sqw_out        (sqw_out),
    .periodic_pulse (periodic_pulse),
    .second_tick    (second_tick)
  );

  assert_hold_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!periodic_pulse && !second_tick));

  assert_tick_single_R9: assert property (@(posedge clk) disable iff (rst)
    second_tick |=> !second_tick);

endmodule

// File: tb/tbase_rate_gen_test.sv
module tbase_rate_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tb_en = 1'b0;
  logic [2:0] osc_ctl = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0;
  logic       pie_en = 1'b0;
  logic       sqw_out, periodic_pulse, second_tick;

  int n_cmp = 0;
  int n_bad = 0;

  logic [14:0] m = '0;
  int pulse_cnt = 0;
  int tick_cnt  = 0;
  int sqw_hi    = 0;
  int steps_since = 0;
  int first_tick_at = -1;

  always #4 clk = ~clk;

  tbase_rate_gen uut (
    .clk(clk), .rst(rst), .tb_en(tb_en), .osc_ctl(osc_ctl),
    .rate_sel(rate_sel), .sqw_en(sqw_en), .pie_en(pie_en),
    .sqw_out(sqw_out), .periodic_pulse(periodic_pulse),
    .second_tick(second_tick)
  );

  // Selected bit from the rate code, derived from the frequency (-1: none).
  function automatic int bit_of(input logic [3:0] rs);
    int freq;
    int f;
    int b;
    if (rs == 4'd0) return -1;
    if (rs == 4'd1)      freq = 256;
    else if (rs == 4'd2) freq = 128;
    else                 freq = 32768 >> (int'(rs) - 1);
    f = 16384;
    b = 0;
    while (f > freq) begin
      f = f >> 1;
      b++;
    end
    return b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: update the model from the inputs present at the edge, then compare.
  task automatic step();
    logic        adv;
    logic        hold;
    logic [14:0] old;
    int          b;
    logic        e_sqw, e_pls, e_tck;
    @(posedge clk);
    adv  = tb_en && (osc_ctl == 3'b010);
    hold = (osc_ctl[2:1] == 2'b11);
    old  = m;
    if (rst || hold) m = '0;
    else if (adv)    m = old + 15'd1;
    b     = bit_of(rate_sel);
    e_sqw = !rst && sqw_en && (b >= 0) && m[b];
    e_pls = !rst && adv && pie_en && (b >= 0) && !old[b] && m[b];
    e_tck = !rst && adv && (old == 15'h7fff);
    #2;
    chk("R7 sqw_out", int'(sqw_out), int'(e_sqw));
    chk("R8 periodic_pulse", int'(periodic_pulse), int'(e_pls));
    chk("R9 second_tick", int'(second_tick), int'(e_tck));
    if (periodic_pulse) pulse_cnt++;
    if (second_tick) tick_cnt++;
    if (sqw_out) sqw_hi++;
    steps_since++;
    if (second_tick && first_tick_at < 0) first_tick_at = steps_since;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    sqw_en = 1'b1; pie_en = 1'b1; tb_en = 1'b1; osc_ctl = 3'b010; rate_sel = 4'd3;
    run(4);
    chk("R1 sqw_out in reset", int'(sqw_out), 0);
    chk("R1 periodic_pulse in reset", int'(periodic_pulse), 0);
    chk("R1 second_tick in reset", int'(second_tick), 0);
    rst = 1'b0;

    // R4: oscillator off from the start, count stays at zero
    osc_ctl = 3'b000;
    pulse_cnt = 0; sqw_hi = 0;
    run(40);
    chk("R4 no pulse while off", pulse_cnt, 0);
    chk("R4 sqw low with frozen zero count", sqw_hi, 0);

    // R2: irregular time-base enable at the fastest rate
    osc_ctl = 3'b010; rate_sel = 4'd3;
    for (int i = 0; i < 300; i++) begin
      tb_en = ((i % 3) != 1) && ((i % 7) != 0);
      step();
    end
    tb_en = 1'b1;

    // R4: freeze mid-count with several off patterns, then resume
    rate_sel = 4'd4;
    run(5);
    for (int p = 0; p < 8; p++) begin
      if (p == 2 || p >= 6) continue;
      osc_ctl = 3'(p);
      pulse_cnt = 0; tick_cnt = 0;
      run(20);
      chk("R4 no pulse for off pattern", pulse_cnt, 0);
      chk("R4 no tick for off pattern", tick_cnt, 0);
    end
    osc_ctl = 3'b010;
    run(30);

    // R5/R6/R7/R8: sweep every rate code from a cleared count
    for (int rs = 0; rs < 16; rs++) begin
      int b;
      int n;
      rate_sel = 4'(rs);
      sqw_en = (rs % 2) == 0;
      pie_en = (rs % 3) != 0;
      osc_ctl = 3'b110;
      run(2);
      osc_ctl = 3'b010;
      b = bit_of(4'(rs));
      n = (b >= 0) ? (1 << (b + 2)) : 64;
      pulse_cnt = 0; sqw_hi = 0;
      run(n);
      if (rs == 0) begin
        chk("R6 no pulse for code 0", pulse_cnt, 0);
        chk("R6 sqw low for code 0", sqw_hi, 0);
      end else begin
        chk("R5 pulses in four half-periods", pulse_cnt, pie_en ? 2 : 0);
        chk("R7 sqw high cycles", sqw_hi, sqw_en ? (n / 2) : 0);
      end
    end

    // R3: hold clears and keeps the count at zero
    rate_sel = 4'd3; sqw_en = 1'b1; pie_en = 1'b1;
    osc_ctl = 3'b111;
    pulse_cnt = 0; tick_cnt = 0; sqw_hi = 0;
    run(20);
    chk("R3 no pulse in hold", pulse_cnt, 0);
    chk("R3 sqw low in hold", sqw_hi, 0);

    // R9: first tick exactly one second after release, then a second later
    osc_ctl = 3'b010;
    steps_since = 0; first_tick_at = -1; tick_cnt = 0;
    run(32768 + 4);
    chk("R9 first tick position", first_tick_at, 32768);
    chk("R9 one tick in first second", tick_cnt, 1);
    run(32768 - 4);
    chk("R9 second tick after wrap", tick_cnt, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule